// File: doc/BRIEF.md
# Dual Capture/Compare Timer Channel

A single timer channel built around a 16-bit up-counter that advances once per clock, plus two general registers (index 0 and index 1). At run time each general register is set to one of two jobs. In compare mode it is checked against the counter on every cycle, and it can drive, clear or toggle its output pin on a match. In capture mode it watches an external pin and stores the counter value when the chosen edge arrives. Each register has a sticky event flag. Software clears a flag by reading it as 1 and then writing 0 to it.

Software reaches the counter, both general registers, the control register and the status register through a plain register port. The port has a write strobe, a read strobe, a 3-bit word address, a 2-bit byte-lane enable and a combinational read-data path. The port has no back-pressure: every access completes in the cycle it is presented, so the port carries no valid/ready pair. A synchronous standby input returns the channel to its reset state. A PWM-mode input makes the per-register I/O settings have no effect.

Top module: `cc_timer_chan`

## Requirements
- R1: Asynchronous reset (rst_n low), and any clock edge with standby_i high, do the following: the counter becomes 0x0000; both general registers become 0xFFFF; both I/O fields become 000, which is compare mode with no pin action; both flags clear; both cmp_o pins go low. The counter stays at 0x0000 while standby_i is held.
- R2: When neither standby nor a counter write is active, the counter rises by one on every clock and wraps from 0xFFFF to 0x0000.
- R3: A write affects only the byte lanes whose enable is set: bus_be_i[0] covers bits 7:0 and bus_be_i[1] covers bits 15:8. A write to the counter takes effect instead of that cycle's increment.
- R4: Address map for bus_addr_i: 0 is the counter; 1 is general register 0; 2 is general register 1; 3 is the control register; 4 is the status register; addresses 5 to 7 read as zero. Bus reads are combinational. The control register holds register 0's I/O field in bits 2:0 and register 1's I/O field in bits 6:4. The status register holds flag 0 in bit 0 and flag 1 in bit 1. All other control and status bits read as zero.
- R5: In compare mode, a cycle in which the counter equals the register sets that register's flag at the next clock edge.
- R6: In compare mode, bits 1:0 of the I/O field select the pin action taken on a match: 00 leaves the pin unchanged, 01 drives it low, 10 drives it high, 11 toggles it.
- R7: Bit 2 of the I/O field set to 1 selects capture mode. The capture pin passes through two synchronizer flops. A pin change made just before clock edge E1 loads the register at edge E3 with the counter value from before E3, and sets the flag at that same edge. After E3 the counter reads one more than the captured value.
- R8: In capture mode, bits 1:0 of the I/O field select the edge: 00 rising only, 01 falling only, 10 or 11 both edges. Edges of the other polarity are ignored.
- R9: A flag stays at 1 until a status write with bus_be_i[0] set and a 0 in the flag's bit. That write clears the flag only if the flag was seen as 1 by an earlier status read. Writing 0 without that earlier read leaves the flag set.
- R10: While pwm_mode_i is high, each register behaves as a compare register with no pin action, whatever its I/O field holds. Matches still set flags, capture edges are ignored, and cmp_o holds its value.
- R11: If a flag-setting event and a valid clear land on the same clock edge, the flag stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby_i | input | 1 | Synchronous return to reset state |
| pwm_mode_i | input | 1 | Makes the I/O fields have no effect |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe (arms flag clearing on status reads) |
| bus_addr_i | input | 3 | Word address |
| bus_be_i | input | 2 | Byte-lane enables |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Combinational read data |
| cap_i | input | 2 | Capture pins, one per general register |
| cmp_o | output | 2 | Compare output pins, one per general register |

## Verification
A wrong counter step or a lost lane merge shows on the next counter read, one cycle later. A compare slip shows within one clock of the matching count, as a missing flag or a wrong cmp_o level. A capture path with the wrong synchronizer depth shows as a register value offset from the counter by the extra flop count, or as a load one cycle early or late. A broken read-then-write clear sequence shows as a flag that clears without the arming read, or as a flag lost when it races a new event. The bench places its samples at exact cycle offsets from each stimulus so that each of these errors is caught.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int unsigned DW = 16;
  localparam int unsigned NB = DW / 8;
  localparam int unsigned AW = 3;

  typedef struct packed {
    logic       cap;
    logic [1:0] sel;
  } ioc_t;

  localparam logic [1:0] ACT_NONE = 2'b00;
  localparam logic [1:0] ACT_LOW  = 2'b01;
  localparam logic [1:0] ACT_HIGH = 2'b10;
  localparam logic [1:0] ACT_TOG  = 2'b11;

  function automatic logic [DW-1:0] lane_merge(
    input logic [DW-1:0] old_v,
    input logic [DW-1:0] new_v,
    input logic [NB-1:0] be
  );
    logic [DW-1:0] r;
    r = old_v;
    for (int i = 0; i < int'(NB); i++)
      if (be[i]) r[8*i +: 8] = new_v[8*i +: 8];
    return r;
  endfunction
endpackage

// File: rtl/cct_counter.sv
module cct_counter
  import cct_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stby_i,
  input  logic [NB-1:0] wr_be_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] cnt_o
);
  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (stby_i)    cnt_q <= '0;
    else if (|wr_be_i)  cnt_q <= lane_merge(cnt_q, wr_data_i, wr_be_i);
    else                cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cct_sync_edge.sv
module cct_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/cct_gr_unit.sv
module cct_gr_unit
  import cct_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stby_i,
  input  logic          pwm_i,
  input  ioc_t          ioc_i,
  input  logic [DW-1:0] cnt_i,
  input  logic          cap_pin_i,
  input  logic [NB-1:0] wr_be_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          st_rd_i,
  input  logic          st_wr_i,
  input  logic          st_bit_i,
  output logic [DW-1:0] gr_o,
  output logic          flag_o,
  output logic          evt_o,
  output logic          clr_o,
  output logic          capm_o,
  output logic          pin_o
);
  logic [DW-1:0] gr_q;
  logic          flag_q, armed_q, pin_q;
  logic          rise, fall, edge_ok, cap_evt, cmp_evt;
  ioc_t          eff;

  cct_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (cap_pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  // PWM mode: I/O field has no effect -> compare, no pin action
  assign eff     = pwm_i ? '0 : ioc_i;
  assign edge_ok = eff.sel[1] ? (rise | fall) : (eff.sel[0] ? fall : rise);
  assign cap_evt = eff.cap & edge_ok;
  assign cmp_evt = ~eff.cap & (cnt_i == gr_q);
  assign evt_o   = cap_evt | cmp_evt;
  assign clr_o   = st_wr_i & ~st_bit_i & armed_q;
  assign capm_o  = eff.cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         gr_q <= '1;
    else if (stby_i)    gr_q <= '1;
    else if (cap_evt)   gr_q <= cnt_i;
    else if (|wr_be_i)  gr_q <= lane_merge(gr_q, wr_data_i, wr_be_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (stby_i) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (evt_o)      flag_q <= 1'b1;
      else if (clr_o) flag_q <= 1'b0;
      if (st_wr_i)                armed_q <= 1'b0;
      else if (st_rd_i && flag_q) armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pin_q <= 1'b0;
    else if (stby_i)  pin_q <= 1'b0;
    else if (cmp_evt) begin
      case (eff.sel)
        ACT_LOW:  pin_q <= 1'b0;
        ACT_HIGH: pin_q <= 1'b1;
        ACT_TOG:  pin_q <= ~pin_q;
        default:  pin_q <= pin_q;
      endcase
    end
  end

  assign gr_o   = gr_q;
  assign flag_o = flag_q;
  assign pin_o  = pin_q;
endmodule

// File: rtl/cc_timer_chan.sv
module cc_timer_chan
  import cct_pkg::*;
#(
  parameter int unsigned NGR         = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           standby_i,
  input  logic           pwm_mode_i,
  input  logic           bus_wr_i,
  input  logic           bus_rd_i,
  input  logic [AW-1:0]  bus_addr_i,
  input  logic [NB-1:0]  bus_be_i,
  input  logic [DW-1:0]  bus_wdata_i,
  output logic [DW-1:0]  bus_rdata_o,
  input  logic [NGR-1:0] cap_i,
  output logic [NGR-1:0] cmp_o
);
  localparam logic [AW-1:0] A_CNT  = '0;
  localparam logic [AW-1:0] A_CTRL = AW'(NGR + 1);
  localparam logic [AW-1:0] A_STAT = AW'(NGR + 2);

  logic [DW-1:0]           cnt_q;
  logic [NGR-1:0][DW-1:0]  gr_all;
  logic [NGR-1:0]          flag_v, evt_v, clr_v, capm_v;
  logic [NB-1:0]           cnt_be;
  logic                    cnt_wr;
  logic                    ctrl_wr, st_wr, st_rd;
  ioc_t                    ioc_q [NGR];

  assign cnt_wr  = bus_wr_i && (bus_addr_i == A_CNT);
  assign cnt_be  = cnt_wr ? bus_be_i : '0;
  assign ctrl_wr = bus_wr_i && (bus_addr_i == A_CTRL);
  assign st_wr   = bus_wr_i && (bus_addr_i == A_STAT) && bus_be_i[0];
  assign st_rd   = bus_rd_i && (bus_addr_i == A_STAT);

  cct_counter u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .stby_i    (standby_i),
    .wr_be_i   (cnt_be),
    .wr_data_i (bus_wdata_i),
    .cnt_o     (cnt_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < int'(NGR); n++) ioc_q[n] <= '0;
    end else if (standby_i) begin
      for (int n = 0; n < int'(NGR); n++) ioc_q[n] <= '0;
    end else if (ctrl_wr) begin
      for (int n = 0; n < int'(NGR); n++)
        if (bus_be_i[(4*n)/8]) ioc_q[n] <= ioc_t'(bus_wdata_i[4*n +: 3]);
    end
  end

  for (genvar g = 0; g < int'(NGR); g++) begin : g_gr
    logic [NB-1:0] gr_be;
    assign gr_be = (bus_wr_i && (bus_addr_i == AW'(g + 1))) ? bus_be_i : '0;

    cct_gr_unit #(.SYNC_STAGES(SYNC_STAGES)) u_gr (
      .clk       (clk),
      .rst_n     (rst_n),
      .stby_i    (standby_i),
      .pwm_i     (pwm_mode_i),
      .ioc_i     (ioc_q[g]),
      .cnt_i     (cnt_q),
      .cap_pin_i (cap_i[g]),
      .wr_be_i   (gr_be),
      .wr_data_i (bus_wdata_i),
      .st_rd_i   (st_rd),
      .st_wr_i   (st_wr),
      .st_bit_i  (bus_wdata_i[g]),
      .gr_o      (gr_all[g]),
      .flag_o    (flag_v[g]),
      .evt_o     (evt_v[g]),
      .clr_o     (clr_v[g]),
      .capm_o    (capm_v[g]),
      .pin_o     (cmp_o[g])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == A_CNT) bus_rdata_o = cnt_q;
    if (bus_addr_i == A_CTRL)
      for (int n = 0; n < int'(NGR); n++) bus_rdata_o[4*n +: 3] = ioc_q[n];
    if (bus_addr_i == A_STAT) bus_rdata_o[NGR-1:0] = flag_v;
    for (int n = 0; n < int'(NGR); n++)
      if (bus_addr_i == AW'(n + 1)) bus_rdata_o = gr_all[n];
  end
endmodule

// File: rtl/cct_checker.sv
module cct_checker
  import cct_pkg::*;
#(
  parameter int unsigned NGR = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   standby_i,
  input logic                   pwm_mode_i,
  input logic                   cnt_wr,
  input logic [DW-1:0]          cnt_q,
  input logic [NGR-1:0][DW-1:0] gr_all,
  input logic [NGR-1:0]         flag_v,
  input logic [NGR-1:0]         evt_v,
  input logic [NGR-1:0]         clr_v,
  input logic [NGR-1:0]         capm_v,
  input logic [NGR-1:0]         cmp_o
);
  AST_STBY_ZERO_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    standby_i |=> cnt_q == '0); // R1

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!standby_i && !cnt_wr) |=> cnt_q == $past(cnt_q) + 1'b1); // R2

  AST_PWM_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!standby_i && pwm_mode_i) |=> cmp_o == $past(cmp_o)); // R10

  for (genvar g = 0; g < int'(NGR); g++) begin : g_chk
    AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (!standby_i && !capm_v[g] && cnt_q == gr_all[g]) |=> flag_v[g]); // R5

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (!standby_i && flag_v[g] && !clr_v[g]) |=> flag_v[g]); // R9

    AST_EVT_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (!standby_i && evt_v[g] && clr_v[g]) |=> flag_v[g]); // R11
  end
endmodule

bind cc_timer_chan cct_checker #(.NGR(NGR)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .standby_i  (standby_i),
  .pwm_mode_i (pwm_mode_i),
  .cnt_wr     (cnt_wr),
  .cnt_q      (cnt_q),
  .gr_all     (gr_all),
  .flag_v     (flag_v),
  .evt_v      (evt_v),
  .clr_v      (clr_v),
  .capm_v     (capm_v),
  .cmp_o      (cmp_o)
);

// File: tb/sim_cc_timer_chan.sv
`timescale 1ns/1ps
module sim_cc_timer_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        standby_i = 1'b0;
  logic        pwm_mode_i = 1'b0;
  logic        bus_wr_i = 1'b0;
  logic        bus_rd_i = 1'b0;
  logic [2:0]  bus_addr_i = '0;
  logic [1:0]  bus_be_i = '0;
  logic [15:0] bus_wdata_i = '0;
  logic [15:0] bus_rdata_o;
  logic [1:0]  cap_i = '0;
  logic [1:0]  cmp_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cc_timer_chan u0 (
    .clk(clk), .rst_n(rst_n), .standby_i(standby_i), .pwm_mode_i(pwm_mode_i),
    .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i), .bus_addr_i(bus_addr_i),
    .bus_be_i(bus_be_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .cap_i(cap_i), .cmp_o(cmp_o)
  );

  localparam logic [2:0] AC = 3'd0, AG0 = 3'd1, AG1 = 3'd2, ACT = 3'd3, AST = 3'd4;

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic [1:0] be);
    bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d; bus_be_i = be;
    @(negedge clk);
    bus_wr_i = 1'b0; bus_be_i = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_rd_i = 1'b1; bus_addr_i = a;
    #1 d = bus_rdata_o;
    @(negedge clk);
    bus_rd_i = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [15:0] d);
    bus_addr_i = a;
    #1 d = bus_rdata_o;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    peek(AG0, v); chk(v == 16'hFFFF, "R1 gr0 reset", v, 16'hFFFF);
    peek(AG1, v); chk(v == 16'hFFFF, "R1 gr1 reset", v, 16'hFFFF);
    peek(ACT, v); chk(v == 16'h0000, "R1 ctrl reset", v, 16'h0000);
    @(negedge clk);
    peek(AST, v); chk(v == 16'h0000, "R1 flags reset", v, 16'h0000);
    chk(cmp_o == 2'b00, "R1 pins reset", {14'd0, cmp_o}, 16'h0000);
    for (int a = 5; a < 8; a++) begin
      peek(3'(a), v); chk(v == 16'h0000, "R4 unused address", v, 16'h0000);
    end
    @(negedge clk);
  endtask

  task automatic t_counter;
    logic [15:0] v, v2;
    wr(AC, 16'h1234, 2'b11);
    wr(AC, 16'h55AB, 2'b01);
    rd(AC, v); chk(v == 16'h12AB, "R3 low lane write", v, 16'h12AB);
    wr(AC, 16'hCD77, 2'b10);
    peek(AC, v); chk(v == 16'hCDAC, "R3 high lane write beats increment", v, 16'hCDAC);
    @(negedge clk);
    peek(AC, v2); chk(v2 == v + 16'd1, "R2 increment", v2, v + 16'd1);
    @(negedge clk);
    wr(AC, 16'hFFFF, 2'b11);
    peek(AC, v); chk(v == 16'hFFFF, "R3 word write", v, 16'hFFFF);
    @(negedge clk);
    peek(AC, v); chk(v == 16'h0000, "R2 wrap", v, 16'h0000);
    @(negedge clk);
  endtask

  task automatic t_compare;
    logic [15:0] v;
    wr(ACT, 16'h0023, 2'b11);
    peek(ACT, v); chk(v == 16'h0023, "R4 ctrl readback", v, 16'h0023);
    @(negedge clk);
    wr(AG0, 16'h0040, 2'b11);
    wr(AG1, 16'h0050, 2'b11);
    wr(AC, 16'h0030, 2'b11);
    wait_n(40);
    peek(AST, v); chk(v == 16'h0003, "R5 both match flags", v, 16'h0003);
    chk(cmp_o == 2'b11, "R6 toggle and drive-high", {14'd0, cmp_o}, 16'h0003);
    @(negedge clk);
    wr(AST, 16'h0000, 2'b01);
    peek(AST, v); chk(v == 16'h0003, "R9 clear without read ignored", v, 16'h0003);
    @(negedge clk);
    rd(AST, v);
    wr(AST, 16'h0000, 2'b01);
    peek(AST, v); chk(v == 16'h0000, "R9 read-then-write clears", v, 16'h0000);
    @(negedge clk);
    wr(ACT, 16'h0021, 2'b01);
    wr(AC, 16'h003C, 2'b11);
    wait_n(10);
    chk(cmp_o == 2'b10, "R6 drive-low action", {14'd0, cmp_o}, 16'h0002);
    wr(ACT, 16'h0023, 2'b01);
    rd(AST, v);
    wr(AST, 16'h0000, 2'b01);
    wr(ACT, 16'h0020, 2'b01);
    wr(AC, 16'h003C, 2'b11);
    wait_n(10);
    chk(cmp_o == 2'b10, "R6 no-output action", {14'd0, cmp_o}, 16'h0002);
    peek(AST, v); chk(v[0] == 1'b1, "R5 flag with no pin action", v, 16'h0001);
    @(negedge clk);
  endtask

  task automatic t_capture;
    logic [15:0] pre, g, c, gb1, gb2;
    wr(ACT, 16'h0064, 2'b01);
    rd(AST, g);
    wr(AST, 16'h0000, 2'b01);
    wait_n(2);
    peek(AG0, pre);
    cap_i[0] = 1'b1;
    wait_n(2);
    peek(AG0, g); chk(g == pre, "R7 no capture before third edge", g, pre);
    @(negedge clk);
    peek(AG0, g);
    peek(AC, c); chk(c == g + 16'd1, "R7 captured counter value", c, g + 16'd1);
    peek(AST, c); chk(c[0] == 1'b1, "R7 flag with capture", c, 16'h0001);
    @(negedge clk);
    cap_i[0] = 1'b0;
    wait_n(6);
    peek(AG0, c); chk(c == g, "R8 falling edge ignored in rising mode", c, g);
    @(negedge clk);
    cap_i[1] = 1'b1;
    wait_n(3);
    peek(AG1, gb1);
    @(negedge clk);
    cap_i[1] = 1'b0;
    wait_n(3);
    peek(AG1, gb2); chk(gb2 == gb1 + 16'd4, "R8 both edges captured", gb2, gb1 + 16'd4);
    @(negedge clk);
  endtask

  task automatic t_pwm;
    logic [15:0] v, gbp;
    logic [1:0] p;
    pwm_mode_i = 1'b1;
    wr(ACT, 16'h0043, 2'b01);
    rd(AST, v);
    wr(AST, 16'h0000, 2'b01);
    p = cmp_o;
    wr(AG0, 16'h0200, 2'b11);
    wr(AC, 16'h01F0, 2'b11);
    wait_n(24);
    peek(AST, v); chk(v[0] == 1'b1, "R10 match still flags", v, 16'h0001);
    chk(cmp_o == p, "R10 pin action suppressed", {14'd0, cmp_o}, {14'd0, p});
    peek(AG1, gbp);
    @(negedge clk);
    cap_i[1] = 1'b1;
    wait_n(5);
    peek(AG1, v); chk(v == gbp, "R10 capture suppressed", v, gbp);
    @(negedge clk);
    pwm_mode_i = 1'b0;
    cap_i[1] = 1'b0;
    wait_n(4);
  endtask

  task automatic t_race;
    logic [15:0] v;
    wr(ACT, 16'h0000, 2'b11);
    wr(AG0, 16'h0300, 2'b11);
    rd(AST, v); chk(v[0] == 1'b1, "R11 flag set before race", v, 16'h0001);
    wr(AC, 16'h02FE, 2'b11);
    wait_n(2);
    wr(AST, 16'h0000, 2'b01);
    peek(AST, v); chk(v[0] == 1'b1, "R11 event beats clear", v, 16'h0001);
    @(negedge clk);
  endtask

  task automatic t_standby;
    logic [15:0] v;
    wr(ACT, 16'h0023, 2'b01);
    standby_i = 1'b1;
    wait_n(3);
    peek(AC, v);  chk(v == 16'h0000, "R1 standby counter held", v, 16'h0000);
    peek(AG0, v); chk(v == 16'hFFFF, "R1 standby gr0", v, 16'hFFFF);
    peek(ACT, v); chk(v == 16'h0000, "R1 standby ctrl", v, 16'h0000);
    @(negedge clk);
    peek(AST, v); chk(v == 16'h0000, "R1 standby flags", v, 16'h0000);
    chk(cmp_o == 2'b00, "R1 standby pins", {14'd0, cmp_o}, 16'h0000);
    @(negedge clk);
    standby_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_counter;
    t_compare;
    t_capture;
    t_pwm;
    t_race;
    t_standby;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R2 actual=hung expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule